// File: doc/BRIEF.md
# UART Internal Loopback and Modem Status Path

This block sits between a UART's register file, its receive queue and its external line pins. It watches every write to the control register, the transmit data strobe and every write to the line-control break bit. When the loopback enable in the control register is set, the block disconnects the outside world. The four software-driven modem control outputs are cross-wired onto the modem status flags and onto the matching raw modem interrupt bits. Each transmitted character is offered to the receive queue push port. A rising break request becomes a queue entry that carries only the break marker.

When loopback is clear, the modem status flags track the four external modem inputs through a synchronizer. Characters and break events from the external receive line are offered to the push port. Transmit writes produce no push. Serial bit timing is not modelled; every push is a single cycle on a registered port.

Top module: `uart_lpbk_top`

## Requirements
- R1: After reset the held control value is 0x300, so loopback is off (`loopbackOn` low), `pushValid` is low and the modem flags and interrupt bits are all zero while the external modem inputs are zero.
- R2: Loopback is enabled by bit 7 of the control value; `loopbackOn` shows that bit one cycle after the control write.
- R3: A control write that sets bit 7 loads the flags in the same write, visible one cycle later: flag bit 8 (ring) takes control bit 13, flag bit 2 (carrier detect) takes bit 12, flag bit 0 (clear to send) takes bit 11, flag bit 1 (data set ready) takes bit 10; all other flag bits read zero.
- R4: While loopback stays on, every control write re-applies the R3 mapping, and the flags do not change in cycles without a control write.
- R5: The raw modem interrupt vector always matches the flags: bit 0 ring, bit 1 clear to send, bit 2 carrier detect, bit 3 data set ready.
- R6: In loopback, a transmit write produces a push one cycle later with the 8-bit character in bits 7:0 and bits 10:8 zero; with loopback off, a transmit write produces no push.
- R7: In loopback, external receive characters and external break events produce no push.
- R8: In loopback, a line-control write that takes the held break bit from 0 to 1 pushes the entry 0x400 (only bit 10 set) one cycle later; a write that leaves the bit at 1 or clears it pushes nothing; when it coincides with a transmit write, the break entry is pushed and the character is dropped.
- R9: With loopback off, the flags follow the external modem inputs (bit 0 clear to send, bit 1 data set ready, bit 2 carrier detect, bit 3 ring) within SYNC_STAGES+1 cycles; an external character is pushed as in R6; an external break pushes 0x400 and takes priority over a character in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrlWrEn | input | 1 | Control register write strobe |
| ctrlWrData | input | 16 | Control register write value |
| txWrEn | input | 1 | Transmit data write strobe |
| txData | input | 8 | Transmitted character |
| lcrWrEn | input | 1 | Line-control register write strobe |
| lcrBrk | input | 1 | Break bit of the line-control write value |
| extRxValid | input | 1 | Character received from the external line |
| extRxData | input | 8 | External received character |
| extBreak | input | 1 | Break detected on the external line |
| extModem | input | 4 | External modem inputs {ring, dcd, dsr, cts} |
| loopbackOn | output | 1 | Loopback currently enabled |
| modemFlags | output | 9 | Modem status flags (bits 0,1,2,8 used) |
| modemIrq | output | 4 | Raw modem interrupt levels |
| pushValid | output | 1 | Receive queue push request |
| pushData | output | 11 | Push entry, bit 10 is the break marker |

## Verification
The assertions assume that the external modem inputs are held long enough for the synchronizer to pass them, and that a break request and a transmit write seen together resolve by the R8 priority rather than being rejected. The random phase keeps the modem inputs constant, so the expected flags in loopback-off cycles follow from the mapping alone. One operation is issued per cycle, with an external character sometimes overlapping it to exercise the blocking and priority paths. Directed cases cover the break-with-transmit collision, a repeated break write and the drop out of loopback.

// File: rtl/uart_lpbk_pkg.sv
package uart_lpbk_pkg;
  localparam int CTRL_W   = 16;
  localparam int LBE_BIT  = 7;
  localparam int RI_SRC   = 13;
  localparam int DCD_SRC  = 12;
  localparam int CTS_SRC  = 11;
  localparam int DSR_SRC  = 10;
  // flag positions
  localparam int FL_CTS   = 0;
  localparam int FL_DSR   = 1;
  localparam int FL_DCD   = 2;
  localparam int FL_RI    = 8;
  localparam int FLAG_W   = 9;
  // raw interrupt positions
  localparam int IQ_RI    = 0;
  localparam int IQ_CTS   = 1;
  localparam int IQ_DCD   = 2;
  localparam int IQ_DSR   = 3;
  localparam int IRQ_W    = 4;
  // internal modem vector order {ri, dcd, dsr, cts}
  localparam int MD_CTS   = 0;
  localparam int MD_DSR   = 1;
  localparam int MD_DCD   = 2;
  localparam int MD_RI    = 3;
  localparam int MD_W     = 4;

  typedef enum logic [2:0] {
    SRC_NONE,
    SRC_TX,
    SRC_LBRK,
    SRC_EXTD,
    SRC_EXTB
  } push_src_e;

  typedef struct packed {
    logic      loadLoop;   // control write enabling loopback
    logic      followExt;  // flags track synchronized inputs
    push_src_e pushSrc;
  } lpbk_strobe_t;
endpackage

// File: rtl/uart_lpbk_ctrl.sv
module uart_lpbk_ctrl
  import uart_lpbk_pkg::*;
#(
  parameter logic [CTRL_W-1:0] CTRL_RESET = 16'h0300
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ctrlWrEn,
  input  logic [CTRL_W-1:0]    ctrlWrData,
  input  logic                 txWrEn,
  input  logic                 lcrWrEn,
  input  logic                 lcrBrk,
  input  logic                 extRxValid,
  input  logic                 extBreak,
  output lpbk_strobe_t         strobe,
  output logic [MD_W-1:0]      loopModem,
  output logic                 loopOn
);
  logic [CTRL_W-1:0] ctrlQ;
  logic              brkQ;
  logic              lbeNext;
  logic              brkRise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrlQ <= CTRL_RESET;
      brkQ  <= 1'b0;
    end else begin
      if (ctrlWrEn) ctrlQ <= ctrlWrData;
      if (lcrWrEn)  brkQ  <= lcrBrk;
    end
  end

  assign loopOn  = ctrlQ[LBE_BIT];
  assign lbeNext = ctrlWrEn ? ctrlWrData[LBE_BIT] : ctrlQ[LBE_BIT];
  assign brkRise = lcrWrEn && lcrBrk && !brkQ;

  always_comb begin
    loopModem          = '0;
    loopModem[MD_RI]   = ctrlWrData[RI_SRC];
    loopModem[MD_DCD]  = ctrlWrData[DCD_SRC];
    loopModem[MD_DSR]  = ctrlWrData[DSR_SRC];
    loopModem[MD_CTS]  = ctrlWrData[CTS_SRC];
  end

  always_comb begin
    strobe.loadLoop  = ctrlWrEn && ctrlWrData[LBE_BIT];
    strobe.followExt = !lbeNext;
    strobe.pushSrc   = SRC_NONE;
    if (loopOn) begin
      if (brkRise)     strobe.pushSrc = SRC_LBRK;
      else if (txWrEn) strobe.pushSrc = SRC_TX;
    end else begin
      if (extBreak)        strobe.pushSrc = SRC_EXTB;
      else if (extRxValid) strobe.pushSrc = SRC_EXTD;
    end
  end

  // R7: with loopback on, external sources never select the push
  a_r7_ext_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    loopOn |-> (strobe.pushSrc != SRC_EXTD && strobe.pushSrc != SRC_EXTB));
  // R6: off loopback, a transmit strobe is never routed into the queue
  a_r6_tx_off: assert property (@(posedge clk) disable iff (!rst_n)
    !loopOn |-> strobe.pushSrc != SRC_TX);
endmodule

// File: rtl/uart_lpbk_dp.sv
module uart_lpbk_dp
  import uart_lpbk_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int ENTRY_W    = DATA_W + 3,
  localparam int BRK_BIT    = DATA_W + 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  lpbk_strobe_t         strobe,
  input  logic [MD_W-1:0]      loopModem,
  input  logic                 loopOn,
  input  logic [DATA_W-1:0]    txData,
  input  logic [DATA_W-1:0]    extRxData,
  input  logic [MD_W-1:0]      extModem,
  output logic [FLAG_W-1:0]    modemFlags,
  output logic [IRQ_W-1:0]     modemIrq,
  output logic                 pushValid,
  output logic [ENTRY_W-1:0]   pushData
);
  logic [MD_W-1:0] syncQ [SYNC_STAGES];
  logic [MD_W-1:0] mdQ;
  logic [MD_W-1:0] mdNext;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) syncQ[g] <= '0;
        else if (g == 0) syncQ[g] <= extModem;
        else syncQ[g] <= syncQ[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  always_comb begin
    mdNext = mdQ;
    if (strobe.loadLoop)       mdNext = loopModem;
    else if (strobe.followExt) mdNext = syncQ[SYNC_STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mdQ      <= '0;
      modemIrq <= '0;
    end else begin
      mdQ              <= mdNext;
      modemIrq[IQ_RI]  <= mdNext[MD_RI];
      modemIrq[IQ_CTS] <= mdNext[MD_CTS];
      modemIrq[IQ_DCD] <= mdNext[MD_DCD];
      modemIrq[IQ_DSR] <= mdNext[MD_DSR];
    end
  end

  always_comb begin
    modemFlags         = '0;
    modemFlags[FL_CTS] = mdQ[MD_CTS];
    modemFlags[FL_DSR] = mdQ[MD_DSR];
    modemFlags[FL_DCD] = mdQ[MD_DCD];
    modemFlags[FL_RI]  = mdQ[MD_RI];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pushValid <= 1'b0;
      pushData  <= '0;
    end else begin
      pushValid <= (strobe.pushSrc != SRC_NONE);
      unique case (strobe.pushSrc)
        SRC_TX:           pushData <= {3'b000, txData};
        SRC_EXTD:         pushData <= {3'b000, extRxData};
        SRC_LBRK, SRC_EXTB: begin
          pushData          <= '0;
          pushData[BRK_BIT] <= 1'b1;
        end
        default:          pushData <= '0;
      endcase
    end
  end

  // R5: interrupt levels track the flags
  a_r5_irq_match: assert property (@(posedge clk) disable iff (!rst_n)
    modemIrq == {modemFlags[FL_DSR], modemFlags[FL_DCD], modemFlags[FL_CTS], modemFlags[FL_RI]});
  // R4: flags hold in loopback without a control write
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (loopOn && !strobe.followExt && !strobe.loadLoop) |=> $stable(modemFlags));
  // R3: same-write mapping of ring indicator
  a_r3_ring_map: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.loadLoop |=> modemFlags[FL_RI] == $past(loopModem[MD_RI]));
  // R8: a break entry carries nothing but the marker
  a_r8_break_only: assert property (@(posedge clk) disable iff (!rst_n)
    (pushValid && pushData[BRK_BIT]) |-> pushData[BRK_BIT-1:0] == '0);
  // R6: looped character lands one cycle later
  a_r6_tx_push: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.pushSrc == SRC_TX) |=> (pushValid && pushData == {3'b000, $past(txData)}));
endmodule

// File: rtl/uart_lpbk_top.sv
module uart_lpbk_top
  import uart_lpbk_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ctrlWrEn,
  input  logic [15:0]          ctrlWrData,
  input  logic                 txWrEn,
  input  logic [DATA_W-1:0]    txData,
  input  logic                 lcrWrEn,
  input  logic                 lcrBrk,
  input  logic                 extRxValid,
  input  logic [DATA_W-1:0]    extRxData,
  input  logic                 extBreak,
  input  logic [3:0]           extModem,
  output logic                 loopbackOn,
  output logic [8:0]           modemFlags,
  output logic [3:0]           modemIrq,
  output logic                 pushValid,
  output logic [DATA_W+2:0]    pushData
);
  lpbk_strobe_t    strobe;
  logic [MD_W-1:0] loopModem;

  uart_lpbk_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrlWrEn   (ctrlWrEn),
    .ctrlWrData (ctrlWrData),
    .txWrEn     (txWrEn),
    .lcrWrEn    (lcrWrEn),
    .lcrBrk     (lcrBrk),
    .extRxValid (extRxValid),
    .extBreak   (extBreak),
    .strobe     (strobe),
    .loopModem  (loopModem),
    .loopOn     (loopbackOn)
  );

  uart_lpbk_dp #(
    .DATA_W      (DATA_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .loopModem  (loopModem),
    .loopOn     (loopbackOn),
    .txData     (txData),
    .extRxData  (extRxData),
    .extModem   (extModem),
    .modemFlags (modemFlags),
    .modemIrq   (modemIrq),
    .pushValid  (pushValid),
    .pushData   (pushData)
  );

  // R7: external traffic in loopback yields no push
  a_r7_no_ext_push: assert property (@(posedge clk) disable iff (!rst_n)
    (loopbackOn && (extRxValid || extBreak) && !txWrEn && !lcrWrEn) |=> !pushValid);
  // R2: enable bit is reflected after the write
  a_r2_enable: assert property (@(posedge clk) disable iff (!rst_n)
    ctrlWrEn |=> loopbackOn == $past(ctrlWrData[7]));
endmodule

// File: tb/uart_lpbk_top_tb_top.sv
`timescale 1ns/1ps
module uart_lpbk_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctrlWrEn = 0;
  logic [15:0] ctrlWrData = '0;
  logic        txWrEn = 0;
  logic [7:0]  txData = '0;
  logic        lcrWrEn = 0;
  logic        lcrBrk = 0;
  logic        extRxValid = 0;
  logic [7:0]  extRxData = '0;
  logic        extBreak = 0;
  logic [3:0]  extModem = '0;
  logic        loopbackOn;
  logic [8:0]  modemFlags;
  logic [3:0]  modemIrq;
  logic        pushValid;
  logic [10:0] pushData;

  int checks = 0;
  int fails  = 0;

  logic [15:0] mCtrl;
  logic        mBrk;

  always #2.5 clk = ~clk;

  uart_lpbk_top dut_i (
    .clk(clk), .rst_n(rst_n), .ctrlWrEn(ctrlWrEn), .ctrlWrData(ctrlWrData),
    .txWrEn(txWrEn), .txData(txData), .lcrWrEn(lcrWrEn), .lcrBrk(lcrBrk),
    .extRxValid(extRxValid), .extRxData(extRxData), .extBreak(extBreak),
    .extModem(extModem), .loopbackOn(loopbackOn), .modemFlags(modemFlags),
    .modemIrq(modemIrq), .pushValid(pushValid), .pushData(pushData)
  );

  function automatic logic [8:0] flagsFromCtrl(input logic [15:0] c);
    logic [8:0] f = '0;
    f[8] = c[13]; f[2] = c[12]; f[0] = c[11]; f[1] = c[10];
    return f;
  endfunction

  function automatic logic [8:0] flagsFromExt(input logic [3:0] e);
    logic [8:0] f = '0;
    f[0] = e[0]; f[1] = e[1]; f[2] = e[2]; f[8] = e[3];
    return f;
  endfunction

  function automatic logic [3:0] irqFromFlags(input logic [8:0] f);
    return {f[1], f[2], f[0], f[8]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clearIn();
    ctrlWrEn = 0; txWrEn = 0; lcrWrEn = 0; extRxValid = 0; extBreak = 0;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic checkPush(input string req, input logic expV, input logic [10:0] expD);
    check(req, {31'd0, pushValid}, {31'd0, expV});
    if (expV) check(req, {21'd0, pushData}, {21'd0, expD});
  endtask

  task automatic checkFlags(input string req, input logic [8:0] expF);
    check(req, {23'd0, modemFlags}, {23'd0, expF});
    check("R5", {28'd0, modemIrq}, {28'd0, irqFromFlags(expF)});
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5678));
    mCtrl = 16'h0300; mBrk = 0;
    repeat (3) @(negedge clk);
    // R1 reset values
    check("R1", {31'd0, loopbackOn}, 0);
    check("R1", {31'd0, pushValid}, 0);
    checkFlags("R1", 9'd0);
    rst_n = 1;
    tick();
    check("R1", {31'd0, loopbackOn}, 0);

    // R9 external modem follow
    extModem = 4'b1010;
    repeat (4) tick();
    checkFlags("R9", flagsFromExt(4'b1010));
    // R6 tx ignored when off
    txWrEn = 1; txData = 8'h5a; tick(); clearIn();
    checkPush("R6", 0, 0);
    // R9 external char and break priority
    extRxValid = 1; extRxData = 8'hc3; tick(); clearIn();
    checkPush("R9", 1, 11'h0c3);
    extRxValid = 1; extBreak = 1; tick(); clearIn();
    checkPush("R9", 1, 11'h400);

    // R3 enable with mapping in same write
    ctrlWrEn = 1; ctrlWrData = 16'h2880; tick(); clearIn();
    mCtrl = 16'h2880;
    check("R2", {31'd0, loopbackOn}, 1);
    checkFlags("R3", flagsFromCtrl(16'h2880));
    // R4 change externals: no effect; rewrite control
    extModem = 4'b0101;
    repeat (3) tick();
    checkFlags("R4", flagsFromCtrl(16'h2880));
    ctrlWrEn = 1; ctrlWrData = 16'h1480; tick(); clearIn();
    mCtrl = 16'h1480;
    checkFlags("R4", flagsFromCtrl(16'h1480));
    // R7 external ignored
    extRxValid = 1; extRxData = 8'h11; tick(); clearIn();
    checkPush("R7", 0, 0);
    extBreak = 1; tick(); clearIn();
    checkPush("R7", 0, 0);
    // R6 tx looped
    txWrEn = 1; txData = 8'ha7; tick(); clearIn();
    checkPush("R6", 1, 11'h0a7);
    // R8 break rise with tx collision
    lcrWrEn = 1; lcrBrk = 1; txWrEn = 1; txData = 8'h33; tick(); clearIn();
    mBrk = 1;
    checkPush("R8", 1, 11'h400);
    lcrWrEn = 1; lcrBrk = 1; tick(); clearIn();
    checkPush("R8", 0, 0);
    lcrWrEn = 1; lcrBrk = 0; tick(); clearIn();
    mBrk = 0;
    checkPush("R8", 0, 0);
    // leave loopback: flags return to externals
    ctrlWrEn = 1; ctrlWrData = 16'h0300; tick(); clearIn();
    mCtrl = 16'h0300;
    check("R2", {31'd0, loopbackOn}, 0);
    checkFlags("R9", flagsFromExt(4'b0101));

    // random phase, externals constant
    for (int i = 0; i < 3000; i++) begin
      logic       expV;
      logic [10:0] expD;
      logic [15:0] nCtrl;
      logic        nBrk;
      int op;
      op = int'($urandom % 6);
      nCtrl = mCtrl; nBrk = mBrk;
      if (op == 0) begin
        ctrlWrEn = 1; ctrlWrData = 16'($urandom);
        nCtrl = ctrlWrData;
      end else if (op == 1) begin
        txWrEn = 1; txData = 8'($urandom);
      end else if (op == 2) begin
        lcrWrEn = 1; lcrBrk = 1'($urandom);
        nBrk = lcrBrk;
        if ($urandom % 2 == 0) begin txWrEn = 1; txData = 8'($urandom); end
      end else if (op == 3) begin
        extRxValid = 1; extRxData = 8'($urandom);
      end else if (op == 4) begin
        extBreak = 1;
      end
      if (op != 3 && ($urandom % 4 == 0)) begin
        extRxValid = 1; extRxData = 8'($urandom);
      end
      expV = 0; expD = '0;
      if (mCtrl[7]) begin
        if (lcrWrEn && lcrBrk && !mBrk) begin expV = 1; expD = 11'h400; end
        else if (txWrEn) begin expV = 1; expD = {3'b000, txData}; end
      end else begin
        if (extBreak) begin expV = 1; expD = 11'h400; end
        else if (extRxValid) begin expV = 1; expD = {3'b000, extRxData}; end
      end
      tick(); clearIn();
      mCtrl = nCtrl; mBrk = nBrk;
      checkPush(mCtrl[7] ? "R8" : "R9", expV, expD);
      check("R2", {31'd0, loopbackOn}, {31'd0, mCtrl[7]});
      checkFlags(mCtrl[7] ? "R3" : "R9",
                 mCtrl[7] ? flagsFromCtrl(mCtrl) : flagsFromExt(extModem));
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule